// File: doc/BRIEF.md
# Decode-Stage Branch Direction Predictor

This block sits beside the decode stage of a pipelined processor. It keeps a table of two-bit saturating direction counters, one per slot. The slot is selected by the low-order word-address bits of the instruction address; the two byte-offset bits, which are always zero for aligned instructions, are skipped. When decode presents a conditional branch, the block reads the slot and turns the counter into a taken or not-taken guess. From that guess it forms a complete next-address guess. A taken guess gives the instruction address plus the sign-extended branch offset. A not-taken guess gives the instruction address plus 4.

The next-address guess is compared with the address that fetch already predicted for the same instruction. When the two differ, the block asks for a fetch redirect to its own guess. The execute stage reports every resolved conditional branch on a separate training port, whether or not it was mispredicted. Each report moves the addressed counter one step toward the observed outcome. The lookup is combinational against the registered table. A training write lands at the next clock edge.

Top module: `dec_bht`

## Requirements
- R1: A synchronous reset sets every counter to 01 (weakly not-taken), so any lookup in the cycle after reset predicts not-taken.
- R2: The predicted direction is the counter's upper bit. Encodings 11 and 10 predict taken; 01 and 00 predict not-taken.
- R3: A taken training report increments the addressed counter. The counter saturates at 11, so repeated taken reports never wrap it to a not-taken value.
- R4: A not-taken training report decrements the addressed counter. The counter saturates at 00, so repeated not-taken reports never wrap it to a taken value.
- R5: From the saturated state on either side, one opposite outcome leaves the prediction unchanged; a second consecutive opposite outcome flips it.
- R6: The slot index is instruction-address bits [IDX_W+1:2]. Address bits 1:0 and the bits above the index have no effect on which slot is read or written.
- R7: The next-address guess is pc + sign-extended offset when the prediction is taken, and pc + 4 when it is not taken. The offset is OFF_W bits wide, and its top bit is the sign bit.
- R8: `redirect_req` is 1 exactly when a branch is presented and the next-address guess differs from the fetch-stage predicted address. The redirect target is `pred_npc`.
- R9: When no branch is presented, both `redirect_req` and `pred_taken` are 0.
- R10: When a lookup and a training report address the same slot in one cycle, the lookup sees the counter value from before that report. The report is visible from the next cycle on.
- R11: A training report changes a counter only when `upd_valid` is 1, and every report is applied regardless of whether it was a misprediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Decoded instruction is a conditional branch |
| lk_pc | input | ADDR_W | Address of the decoded instruction |
| lk_boff | input | OFF_W | Signed branch offset in bytes |
| lk_fetch_npc | input | ADDR_W | Next address that fetch predicted |
| upd_valid | input | 1 | A resolved branch outcome is reported |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction, 1 = taken |
| pred_taken | output | 1 | Direction guess for the decoded branch |
| pred_npc | output | ADDR_W | Next-address guess |
| redirect_req | output | 1 | Fetch redirect request to `pred_npc` |

## Verification
A counter slot is walked up and down past both saturation points. This separates a correct saturating counter from one that wraps, and the single-step reversal shows the hysteresis. Addresses that differ only in the byte-offset bits or only above the index must share a slot. This catches an index taken from the wrong bit range. A same-slot lookup and report in one cycle tells old-value reads from write-through reads. Fetch guesses that sometimes match and sometimes miss, together with negative and positive offsets, exercise the redirect compare and the target adder. A long random stream over a few colliding slots is then compared against a behavioural model every cycle.

// File: rtl/bht_pkg.sv
package bht_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } dir_ctr_t;

    localparam dir_ctr_t CTR_INIT = CTR_WEAK_NT;

    typedef struct packed {
        logic     hit;
        logic     taken;
        dir_ctr_t ctr;
    } dir_guess_t;

    function automatic dir_ctr_t ctr_step(input dir_ctr_t cur, input logic taken);
        dir_ctr_t nxt;
        nxt = cur;
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_INIT;
        endcase
        return nxt;
    endfunction

    function automatic logic ctr_dir(input dir_ctr_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    localparam int LO = 2;
    localparam int HI = IDX_W + LO - 1;

    logic unused_pc_bits;

    assign idx            = pc[HI:LO];
    assign unused_pc_bits = ^{pc[LO-1:0], pc[ADDR_W-1:HI+1]};
endmodule

// File: rtl/bht_table.sv
module bht_table
    import bht_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output dir_ctr_t         rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    dir_ctr_t ctr_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                ctr_q[g] <= CTR_INIT;
            end else if (sel) begin
                ctr_q[g] <= ctr_step(ctr_q[g], wr_taken);
            end
        end
    end

    assign rd_ctr = ctr_q[rd_idx];
endmodule

// File: rtl/bht_nextpc.sv
module bht_nextpc
    import bht_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 13
) (
    input  dir_guess_t        guess,
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  boff,
    input  logic [ADDR_W-1:0] fetch_npc,
    output logic [ADDR_W-1:0] npc,
    output logic              mismatch
);
    localparam int EXT_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] tgt_taken;
    logic [ADDR_W-1:0] tgt_fall;

    always_comb begin
        off_ext   = {{EXT_W{boff[OFF_W-1]}}, boff};
        tgt_taken = pc + off_ext;
        tgt_fall  = pc + INSN_BYTES;
        npc       = guess.taken ? tgt_taken : tgt_fall;
        mismatch  = guess.hit && (npc != fetch_npc);
    end
endmodule

// File: rtl/dec_bht.sv
module dec_bht
    import bht_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [OFF_W-1:0]  lk_boff,
    input  logic [ADDR_W-1:0] lk_fetch_npc,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_npc,
    output logic              redirect_req
);
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;
    dir_ctr_t         lk_ctr;
    dir_guess_t       guess;

    bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bht_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_index (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    bht_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_ctr   (lk_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    always_comb begin
        guess.hit   = lk_valid;
        guess.ctr   = lk_ctr;
        guess.taken = lk_valid && ctr_dir(lk_ctr);
    end

    bht_nextpc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_nextpc (
        .guess     (guess),
        .pc        (lk_pc),
        .boff      (lk_boff),
        .fetch_npc (lk_fetch_npc),
        .npc       (pred_npc),
        .mismatch  (redirect_req)
    );

    assign pred_taken = guess.taken;
endmodule

// File: rtl/dec_bht_chk.sv
module dec_bht_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [ADDR_W-1:0] lk_pc,
    input logic [OFF_W-1:0]  lk_boff,
    input logic [ADDR_W-1:0] lk_fetch_npc,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_npc,
    input logic              redirect_req
);
    logic [IDX_W-1:0] c_lk_idx;
    logic [IDX_W-1:0] c_upd_idx;
    logic             same_slot;
    logic             unused_chk;

    assign c_lk_idx   = lk_pc[IDX_W+1:2];
    assign c_upd_idx  = upd_pc[IDX_W+1:2];
    assign same_slot  = c_lk_idx == c_upd_idx;
    assign unused_chk = ^lk_boff;

    // R8 / R9: a redirect only accompanies a presented branch
    a_r8_redirect_needs_branch: assert property (@(posedge clk) disable iff (rst)
        redirect_req |-> lk_valid);

    // R8: a presented branch whose guess differs from fetch must redirect
    a_r8_redirect_on_mismatch: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && (pred_npc != lk_fetch_npc)) |-> redirect_req);

    // R9: no direction guess without a branch
    a_r9_idle_not_taken: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !pred_taken);

    // R7: not-taken guess falls through to the next word
    a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !pred_taken) |-> (pred_npc == lk_pc + ADDR_W'(4)));

    // R1: first lookup after reset predicts not-taken
    a_r1_reset_weak_nt: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lk_valid) |-> !pred_taken);

    // R3: taken prediction reinforced by a taken report stays taken
    a_r3_taken_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid && pred_taken && upd_valid && upd_taken && same_slot)
         && lk_valid && (c_lk_idx == $past(c_lk_idx))) |-> pred_taken);

    // R4: not-taken prediction reinforced by a not-taken report stays not-taken
    a_r4_not_taken_holds: assert property (@(posedge clk) disable iff (rst)
        ($past(lk_valid && !pred_taken && upd_valid && !upd_taken && same_slot)
         && lk_valid && (c_lk_idx == $past(c_lk_idx))) |-> !pred_taken);
endmodule

bind dec_bht dec_bht_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/dec_bht_tb.sv
module dec_bht_tb;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 10;
    localparam int OFF_W  = 13;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [ADDR_W-1:0] lk_pc = '0;
    logic [OFF_W-1:0]  lk_boff = '0;
    logic [ADDR_W-1:0] lk_fetch_npc = '0;
    logic              upd_valid = 1'b0;
    logic [ADDR_W-1:0] upd_pc = '0;
    logic              upd_taken = 1'b0;
    logic              pred_taken;
    logic [ADDR_W-1:0] pred_npc;
    logic              redirect_req;

    int n_checks = 0;
    int n_fails  = 0;
    int model [DEPTH];

    always #5 clk = ~clk;

    dec_bht #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_boff(lk_boff),
        .lk_fetch_npc(lk_fetch_npc), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .pred_taken(pred_taken), .pred_npc(pred_npc),
        .redirect_req(redirect_req)
    );

    function automatic int slot(input logic [ADDR_W-1:0] pc);
        return int'((pc >> 2) % DEPTH);
    endfunction

    task automatic chk(input string tag, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, compare against the model, then apply the report to the model.
    task automatic step(input string tag, input logic v, input logic [ADDR_W-1:0] pc,
                        input logic [OFF_W-1:0] boff, input logic [ADDR_W-1:0] fnpc,
                        input logic uv, input logic [ADDR_W-1:0] upc, input logic ut);
        logic              e_taken;
        logic [ADDR_W-1:0] e_npc;
        logic [ADDR_W-1:0] off32;
        lk_valid = v; lk_pc = pc; lk_boff = boff; lk_fetch_npc = fnpc;
        upd_valid = uv; upd_pc = upc; upd_taken = ut;
        #1;
        off32   = {{(ADDR_W-OFF_W){boff[OFF_W-1]}}, boff};
        e_taken = v && (model[slot(pc)] >= 2);
        e_npc   = e_taken ? pc + off32 : pc + 32'd4;
        chk(tag, {31'd0, pred_taken}, {31'd0, e_taken});
        if (v) chk(tag, pred_npc, e_npc);
        chk(tag, {31'd0, redirect_req}, {31'd0, v && (e_npc != fnpc)});
        @(posedge clk);
        if (uv) begin
            if (ut) model[slot(upc)] = (model[slot(upc)] == 3) ? 3 : model[slot(upc)] + 1;
            else    model[slot(upc)] = (model[slot(upc)] == 0) ? 0 : model[slot(upc)] - 1;
        end
        @(negedge clk);
    endtask

    task automatic train(input string tag, input logic [ADDR_W-1:0] upc, input logic ut);
        step(tag, 1'b0, 32'h0, 13'd0, 32'h0, 1'b1, upc, ut);
    endtask

    task automatic look(input string tag, input logic [ADDR_W-1:0] pc, input logic [OFF_W-1:0] boff,
                        input logic [ADDR_W-1:0] fnpc);
        step(tag, 1'b1, pc, boff, fnpc, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished at %0t", $time);
        finish_run();
    end

    localparam logic [ADDR_W-1:0] PA = 32'h0000_1230;
    localparam logic [ADDR_W-1:0] PB = 32'h0000_2F48;

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all slots weakly not-taken after reset
        look("R1", PA, 13'd16, PA + 4);
        look("R1", PB, 13'd64, PB + 4);
        // R9: no branch presented, mismatching fetch address
        step("R9", 1'b0, PA, 13'd16, PA + 100, 1'b0, 32'h0, 1'b0);
        // R11: report with upd_valid low is ignored
        step("R11", 1'b0, PA, 13'd0, 32'h0, 1'b0, PA, 1'b1);
        look("R11", PA, 13'd16, PA + 4);
        // R2: one taken report flips 01 to 10 -> taken; R8 redirect since fetch said pc+4
        train("R11", PA, 1'b1);
        look("R2", PA, 13'd16, PA + 4);
        look("R8", PA, 13'd16, PA + 16);
        // R3: saturate at 11
        train("R3", PA, 1'b1);
        train("R3", PA, 1'b1);
        train("R3", PA, 1'b1);
        look("R3", PA, 13'd16, PA + 16);
        // R5: one not-taken leaves it taken, second flips it
        train("R5", PA, 1'b0);
        look("R5", PA, 13'd16, PA + 4);
        train("R5", PA, 1'b0);
        look("R5", PA, 13'd16, PA + 4);
        // R4: saturate at 00, then one taken must still be not-taken
        train("R4", PA, 1'b0);
        train("R4", PA, 1'b0);
        train("R4", PA, 1'b0);
        train("R4", PA, 1'b1);
        look("R4", PA, 13'd16, PA + 4);
        // R6: aliases in high bits and low bits share the slot
        train("R6", PA + (32'd1 << (IDX_W + 2)), 1'b1);
        look("R6", PA, 13'd16, PA + 16);
        look("R6", PA | 32'd3, 13'd16, PA + 4);
        look("R6", PA + (32'd5 << (IDX_W + 2)), 13'd16, PA + 4);
        // R7: negative offset target
        look("R7", PA, 13'h1FF8, PA - 8);
        look("R7", PB, 13'h1000, PB + 4);
        // R10: same-slot lookup and report in one cycle sees the old value
        step("R10", 1'b1, PB, 13'd32, PB + 4, 1'b1, PB, 1'b1);
        look("R10", PB, 13'd32, PB + 4);

        // Random stream over a few colliding slots
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] rpc;
            logic [ADDR_W-1:0] upc;
            logic [OFF_W-1:0]  bo;
            logic [ADDR_W-1:0] fn;
            rpc = PA + (($urandom % 4) << 2) + (($urandom % 3) << (IDX_W + 2));
            upc = PA + (($urandom % 4) << 2) + (($urandom % 3) << (IDX_W + 2));
            bo  = OFF_W'($urandom) & 13'h1FFC;
            case ($urandom % 3)
                0: fn = rpc + 4;
                1: fn = rpc + {{(ADDR_W-OFF_W){bo[OFF_W-1]}}, bo};
                default: fn = $urandom;
            endcase
            step("R8", 1'($urandom), rpc, bo, fn, 1'($urandom), upc, 1'($urandom));
        end

        // R1: reset mid-run returns every slot to weakly not-taken
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = 1;
        look("R1", PA, 13'd16, PA + 4);
        look("R1", PA + 4, 13'd16, PA + 8);
        finish_run();
    end
endmodule